// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a block of words from one region of a shared memory bus to another while it borrows the bus from the processor. Software writes a source base, a destination base, a word count and a control word. It then writes a start command. The engine raises a bus request and waits for the grant. Each word is moved as a read of the source followed by a write of the returned data to the destination.

Each side can step by one word address after every word, or it can stay on one address so that a peripheral data register can be drained or filled. A burst/single selector sets how long the bus is held. In burst mode the request stays up for the whole block. In single mode the bus is handed back after every word, and a fresh request/grant exchange follows. After each release the engine waits until it sees the grant fall before it asks again. A done flag can drive a level interrupt when interrupts are enabled. Software clears the flag by writing a one to it.

Top module: `xfer_engine`

## Requirements
- R1: Configuration writes use `cfg_sel`: 0 = source base, 1 = destination base, 2 = word count (low 16 bits), 3 = control (bit0 source step, bit1 destination step, bit2 burst, bit3 interrupt enable), 4 = command (bit0 = start), 5 = status (bit0 write-one-to-clear done). An accepted start takes a snapshot of base, count and control. Register writes made during a transfer do not change the transfer in progress.
- R2: Each word is a one-cycle read (`mem_rd`) at the source address. The next cycle is a one-cycle write (`mem_wr`) at the destination address, with `mem_wdata` equal to `mem_rdata`. The memory returns read data in the cycle after `mem_rd`.
- R3: Source and destination addresses are word addresses. After each word, a side whose step bit is 1 advances by one, and a side whose step bit is 0 stays on its base address.
- R4: In burst mode the request stays high from the first grant until the last word of the block has been written, so each block has exactly one request rise.
- R5: In single mode the request drops in the cycle after every word write and rises again for the next word, so a block of N words has N request rises.
- R6: The request never rises while `bus_gnt` is high. After a release, the engine waits until it has seen the grant low.
- R7: A block moves exactly the programmed count of words, from 1 to 65535, with overlapping regions handled in word order.
- R8: A count of zero sets done at the same edge that accepts the start, raises no request and leaves `busy` low.
- R9: `busy` is high from an accepted start until the end of the block. A start command written while `busy` is high is ignored.
- R10: `irq` is high exactly while done is set and the interrupt enable snapshot is 1. Writing 1 to status bit0 clears done, writing 0 leaves it set, and a new start also clears it.
- R11: While `bus_gnt` is low, `mem_rd` and `mem_wr` are 0 and `mem_addr` is 0.
- R12: After reset, `busy`, `done_sts`, `irq`, `bus_req`, `mem_rd` and `mem_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| busy | output | 1 | Transfer in progress |
| done_sts | output | 1 | Block complete flag |
| irq | output | 1 | Level completion interrupt |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_rd` |

## Verification
A wrong sequencer state shows on the bus at once. It appears as a request that rises while the grant is still high, as a strobe with no grant, or as a write that has no read in the cycle before it, and each of these is visible in the cycle where it happens. A wrong word count or a wrong step setting on one side only shows once the block is over, as a changed destination image or a wrong number of request rises. The bench therefore compares the whole memory against a model after each block. A done or interrupt fault shows in the cycle after the block's last release, or in the cycle after a start with a count of zero.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int CFG_W = 32;

    localparam logic [2:0] SEL_SRC = 3'd0;
    localparam logic [2:0] SEL_DST = 3'd1;
    localparam logic [2:0] SEL_LEN = 3'd2;
    localparam logic [2:0] SEL_CTL = 3'd3;
    localparam logic [2:0] SEL_CMD = 3'd4;
    localparam logic [2:0] SEL_STS = 3'd5;

    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_RD, S_WR, S_REL
    } seq_t;

    // packed so that src_step sits on bit0 of the control word
    typedef struct packed {
        logic irq_en;
        logic burst;
        logic dst_step;
        logic src_step;
    } ctl_t;

    function automatic ctl_t ctl_decode(input logic [3:0] raw);
        ctl_t c;
        c.src_step = raw[0];
        c.dst_step = raw[1];
        c.burst    = raw[2];
        c.irq_en   = raw[3];
        return c;
    endfunction
endpackage

// File: rtl/xfer_regs.sv
module xfer_regs
    import xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       sel,
    input  logic [CFG_W-1:0] wdata,
    input  logic             busy,
    input  logic             set_done,
    output logic [AW-1:0]    src_base,
    output logic [AW-1:0]    dst_base,
    output logic [LW-1:0]    len,
    output ctl_t             ctl,
    output logic             start,
    output logic             done_q
);
    logic clr_req;

    assign start   = we && (sel == SEL_CMD) && wdata[0] && !busy;
    assign clr_req = we && (sel == SEL_STS) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_base <= '0;
            dst_base <= '0;
            len      <= '0;
            ctl      <= '0;
        end else if (we) begin
            case (sel)
                SEL_SRC: src_base <= wdata[AW-1:0];
                SEL_DST: dst_base <= wdata[AW-1:0];
                SEL_LEN: len      <= wdata[LW-1:0];
                SEL_CTL: ctl      <= ctl_decode(wdata[3:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    done_q <= 1'b0;
        else if (set_done)          done_q <= 1'b1;
        else if (start || clr_req)  done_q <= 1'b0;
    end
endmodule

// File: rtl/xfer_addr.sv
module xfer_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step_en,
    input  logic          step,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)                  addr <= '0;
        else if (load)            addr <= base;
        else if (step && step_en) addr <= addr + AW'(1);
    end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [LW-1:0] len,
    input  ctl_t          ctl_in,
    input  logic          gnt,
    output ctl_t          act_ctl,
    output logic [LW-1:0] remain,
    output logic          req,
    output logic          rd_en,
    output logic          wr_en,
    output logic          set_done,
    output logic          busy
);
    seq_t st;
    logic last_word;

    assign last_word = (remain == LW'(1));
    assign req      = (st == S_REQ) || (st == S_RD) || (st == S_WR);
    assign rd_en    = (st == S_RD) && gnt;
    assign wr_en    = (st == S_WR) && gnt;
    assign busy     = (st != S_IDLE);
    assign set_done = ((st == S_IDLE) && start && (len == '0)) ||
                      ((st == S_REL) && !gnt && (remain == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            remain  <= '0;
            act_ctl <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    act_ctl <= ctl_in;
                    remain  <= len;
                    if (len != '0) st <= S_REQ;
                end
                S_REQ: if (gnt) st <= S_RD;
                S_RD:  if (gnt) st <= S_WR;
                S_WR:  if (gnt) begin
                    remain <= remain - LW'(1);
                    if (last_word || !act_ctl.burst) st <= S_REL;
                    else                             st <= S_RD;
                end
                S_REL: if (!gnt) st <= (remain == '0) ? S_IDLE : S_REQ;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             busy,
    output logic             done_sts,
    output logic             irq,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata
);
    localparam int NSIDE = 2;

    logic [AW-1:0] src_base, dst_base;
    logic [LW-1:0] len_reg;
    logic [LW-1:0] remain;
    ctl_t          ctl_reg, act_ctl;
    logic          start, set_done, rd_en, wr_en;
    logic          act_burst;

    logic [AW-1:0] side_base [NSIDE];
    logic          side_step [NSIDE];
    logic [AW-1:0] side_addr [NSIDE];

    xfer_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .busy(busy), .set_done(set_done),
        .src_base(src_base), .dst_base(dst_base), .len(len_reg), .ctl(ctl_reg),
        .start(start), .done_q(done_sts)
    );

    xfer_seq #(.LW(LW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .len(len_reg), .ctl_in(ctl_reg),
        .gnt(bus_gnt), .act_ctl(act_ctl), .remain(remain), .req(bus_req),
        .rd_en(rd_en), .wr_en(wr_en), .set_done(set_done), .busy(busy)
    );

    assign side_base[0] = src_base;
    assign side_base[1] = dst_base;
    assign side_step[0] = act_ctl.src_step;
    assign side_step[1] = act_ctl.dst_step;

    // index 0 walks the source, index 1 the destination
    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        xfer_addr #(.AW(AW)) u_addr (
            .clk(clk), .rst(rst), .load(start), .base(side_base[g]),
            .step_en(side_step[g]), .step(wr_en), .addr(side_addr[g])
        );
    end

    assign act_burst = act_ctl.burst;
    assign mem_rd    = rd_en;
    assign mem_wr    = wr_en;
    assign mem_wdata = wr_en ? mem_rdata : '0;
    assign irq       = done_sts && act_ctl.irq_en;

    always_comb begin
        mem_addr = '0;
        if (rd_en)      mem_addr = side_addr[0];
        else if (wr_en) mem_addr = side_addr[1];
    end
endmodule

// File: rtl/xfer_chk.sv
module xfer_chk #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done_sts,
    input logic          irq,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          act_burst,
    input logic [LW-1:0] remain
);
    assert_no_strobe_without_grant_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_gnt |-> (!mem_rd && !mem_wr && mem_addr == '0));

    assert_req_waits_release_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !bus_gnt);

    assert_burst_holds_bus_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && act_burst && remain != LW'(1)) |=> bus_req);

    assert_single_releases_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !act_burst) |=> !bus_req);

    assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd));

    assert_rd_wr_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_irq_needs_done_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> done_sts);

    assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);
endmodule

bind xfer_engine xfer_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done_sts(done_sts), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .act_burst(act_burst), .remain(remain)
);

// File: tb/tb_xfer_engine.sv
`timescale 1ns/1ps
module tb_xfer_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        busy, done_sts, irq, bus_req, mem_rd, mem_wr;
    logic        bus_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xfer_engine dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .done_sts(done_sts), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // memory and arbiter models
    logic [31:0] mem [256];
    logic [31:0] exp_mem [256];
    logic        fill_req = 1'b0;
    logic [7:0]  seed = '0;
    logic        prev_req = 1'b0;
    int          rises = 0, viol = 0;

    function automatic logic [31:0] pat(input int i, input logic [7:0] s);
        return {s, 8'h5A, 16'(i * 7 + 3)};
    endfunction

    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i, seed);
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    always @(posedge clk) begin
        if (rst) bus_gnt <= 1'b0;
        else     bus_gnt <= bus_req;
    end

    always @(posedge clk) begin
        prev_req <= bus_req;
        if (!rst && bus_req && !prev_req) begin
            rises <= rises + 1;
            if (bus_gnt) viol <= viol + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fill(input logic [7:0] s);
        @(negedge clk);
        seed = s; fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
        for (int i = 0; i < 256; i++) exp_mem[i] = pat(i, s);
    endtask

    task automatic model(input int src, input int dst, input int len, input logic [3:0] c);
        for (int k = 0; k < len; k++) begin
            int s_a = (src + (c[0] ? k : 0)) & 255;
            int d_a = (dst + (c[1] ? k : 0)) & 255;
            exp_mem[d_a] = exp_mem[s_a];
        end
    endtask

    task automatic wait_done();
        for (int n = 0; n < 4000 && !done_sts; n++) @(negedge clk);
    endtask

    function automatic int mem_mismatch();
        int m = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) m++;
        return m;
    endfunction

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] len;
        logic [3:0]  ctl;    // bit0 src step, bit1 dst step, bit2 burst, bit3 irq enable
        logic [15:0] rises;
        logic        irq;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'd10, 32'd100, 16'd5, 4'b1111, 16'd1, 1'b1},  // burst, both step
        '{32'd20, 32'd150, 16'd4, 4'b0011, 16'd4, 1'b0},  // single, both step
        '{32'd30, 32'd200, 16'd3, 4'b1010, 16'd3, 1'b1},  // fixed source
        '{32'd40, 32'd250, 16'd6, 4'b0101, 16'd1, 1'b0},  // fixed destination
        '{32'd60, 32'd61,  16'd4, 4'b0111, 16'd1, 1'b0},  // overlap
        '{32'd5,  32'd90,  16'd1, 4'b1011, 16'd1, 1'b1}   // single word
    };

    initial begin
        #(4 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int r0, mm;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done_sts, irq, bus_req, mem_rd, mem_wr} == 6'b0, "R12 reset outputs",
            {busy, done_sts, irq, bus_req, mem_rd, mem_wr}, 0);

        for (int v = 0; v < NV; v++) begin
            fill(8'(v + 1));
            wr(3'd0, VECS[v].src);
            wr(3'd1, VECS[v].dst);
            wr(3'd2, 32'(VECS[v].len));
            wr(3'd3, 32'(VECS[v].ctl));
            model(int'(VECS[v].src), int'(VECS[v].dst), int'(VECS[v].len), VECS[v].ctl);
            r0 = rises;
            wr(3'd4, 32'd1);
            if (v == 0) begin
                // first cycle after start: request up, grant not yet given
                chk(bus_req && busy && !mem_rd && !mem_wr && mem_addr == 0,
                    "R11 no strobe before grant", {bus_req, mem_rd, mem_wr}, 3'b100);
            end
            wait_done();
            @(negedge clk);
            mm = mem_mismatch();
            chk(mm == 0, "R2 R3 R7 memory image", mm, 0);
            chk(rises - r0 == int'(VECS[v].rises), "R4 R5 request rises", rises - r0, VECS[v].rises);
            chk(irq == VECS[v].irq && !busy, "R10 irq level", irq, VECS[v].irq);
            wr(3'd5, 32'd0);
            chk(done_sts == 1'b1, "R10 zero write keeps done", done_sts, 1);
            wr(3'd5, 32'd1);
            chk(!done_sts && !irq, "R10 w1c clears done", {done_sts, irq}, 0);
        end

        // zero length
        fill(8'h20);
        wr(3'd2, 32'd0);
        wr(3'd3, 32'h8);
        r0 = rises;
        wr(3'd4, 32'd1);
        chk(done_sts && irq && !busy && !bus_req, "R8 zero count done", {done_sts, irq, busy, bus_req}, 4'b1100);
        repeat (5) @(negedge clk);
        chk(rises == r0 && mem_mismatch() == 0, "R8 zero count no bus", rises - r0, 0);
        wr(3'd5, 32'd1);

        // start and register writes while busy are ignored
        fill(8'h30);
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd128);
        wr(3'd2, 32'd8);
        wr(3'd3, 32'h7);
        model(0, 128, 8, 4'h7);
        r0 = rises;
        wr(3'd4, 32'd1);
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        wr(3'd0, 32'd5);
        wr(3'd2, 32'd2);
        wr(3'd3, 32'h3);
        wr(3'd4, 32'd1);
        wait_done();
        @(negedge clk);
        mm = mem_mismatch();
        chk(mm == 0, "R9 R1 restart ignored", mm, 0);
        chk(rises - r0 == 1, "R1 mode snapshot", rises - r0, 1);
        wr(3'd5, 32'd1);

        // new start clears done, then runs the reprogrammed block
        fill(8'h40);
        wr(3'd4, 32'd1);
        chk(!done_sts && busy, "R10 start clears done", done_sts, 0);
        wait_done();
        @(negedge clk);
        model(5, 128, 2, 4'h3);
        chk(mem_mismatch() == 0, "R1 reprogrammed block", mem_mismatch(), 0);

        chk(viol == 0, "R6 request only after grant low", viol, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule